// File: doc/BRIEF.md
# SPI FIFO Interrupt Status Controller

This block gathers the interrupt conditions of an SPI master whose receive and transmit FIFOs each hold 64 bytes. It watches the two FIFO fill counts and three single-cycle event pulses from the exchange engine: burst complete, receive overflow and transmit underrun. It records each condition in a six-bit status register and drives one interrupt line, which is the registered OR of every pending bit whose enable is set.

Software reads the status bits and clears them by writing ones. It programs the enables through a separate write port. The event sources are sticky: a pulse sets the bit, and the bit holds until software clears it. The three FIFO-level sources are re-evaluated every cycle, so clearing one of them has a lasting effect only once its level condition has gone away. A status bit records its condition whether or not the matching enable is set.

Top module: `spi_irq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, status, enable and irq are all zero when no condition is present (rx_count 0, tx_count 64, no pulses).
- R2: The status bits are assigned as follows: bit 0 is burst complete, bit 1 is RX overflow, bit 2 is TX underrun, bit 3 is RX ready, bit 4 is RX half-full and bit 5 is TX half-empty. A pulse on done_pulse, rx_ovf_pulse or tx_udr_pulse sets bit 0, 1 or 2 respectively at the next clock edge, and the bit then stays set until it is cleared.
- R3: When sta_wr is high, each status bit whose sta_wdata bit is one is cleared at the clock edge. A status bit whose sta_wdata bit is zero keeps its value. Writing 6'h3F clears every bit whose condition is absent.
- R4: If a clear and a set condition for the same bit occur in the same cycle, the bit is one after the edge.
- R5: Status bit 3 is set at the clock edge whenever rx_count is 1 or more.
- R6: Status bit 4 is set at the clock edge whenever rx_count is 32 (half the depth) or more.
- R7: Status bit 5 is set at the clock edge whenever tx_count is 32 or less.
- R8: A level bit that is cleared while its condition still holds is one again after that same edge.
- R9: When en_wr is high, enable takes the value of en_wdata at the clock edge. Otherwise enable holds its value. Status bits are set even when their enable bit is zero.
- R10: irq equals the OR of (status AND enable), registered, so it is valid one clock after status and enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 7 | Receive FIFO fill level in bytes |
| tx_count | input | 7 | Transmit FIFO fill level in bytes |
| done_pulse | input | 1 | Burst-complete event |
| rx_ovf_pulse | input | 1 | Receive overflow event |
| tx_udr_pulse | input | 1 | Transmit underrun event |
| sta_wr | input | 1 | Status write-one-to-clear strobe |
| sta_wdata | input | 6 | Clear mask |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 6 | New enable value |
| status | output | 6 | Pending source bits |
| enable | output | 6 | Per-source enable bits |
| irq | output | 1 | Interrupt request |

## Verification
Every FIFO fill count from 0 to 64 is applied while every bit is being cleared. The level bits that come out then show each threshold edge by itself, which separates a comparison off by one from a correct one. It also shows the re-set that follows a clear. All 64 pairs of event pulses and clear masks are then applied on top of latched event bits. This separates set-over-clear priority, per-bit clearing and stickiness. Finally, all 64 enable values are combined with eight status patterns, so the registered OR is tried with each enable bit both alone and masked.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int unsigned NSRC = 6;

   typedef enum int unsigned {
      SRC_DONE  = 0,
      SRC_RXOVF = 1,
      SRC_TXUDR = 2,
      SRC_RXRDY = 3,
      SRC_RXHF  = 4,
      SRC_TXHE  = 5
   } src_e;

   typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/spi_irq_levels.sv
module spi_irq_levels #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   output logic             rx_rdy,
   output logic             rx_hf,
   output logic             tx_he
);
   localparam int unsigned HALF = DEPTH / 2;
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

   always_comb begin
      rx_rdy = (rx_count != '0);
      rx_hf  = (rx_count >= HALF_C);
      tx_he  = (tx_count <= HALF_C);
   end
endmodule

// File: rtl/spi_irq_bank.sv
module spi_irq_bank
   import spi_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t set_vec,
   input  logic     clr_wr,
   input  src_vec_t clr_mask,
   output src_vec_t sta_q
);
   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sta_q[i] <= 1'b0;
         else
            sta_q[i] <= set_vec[i] | (sta_q[i] & ~(clr_wr & clr_mask[i]));
      end
   end
endmodule

// File: rtl/spi_irq_gate.sv
module spi_irq_gate
   import spi_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en_wr,
   input  src_vec_t en_wdata,
   input  src_vec_t sta_q,
   output src_vec_t en_q,
   output logic     irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         if (en_wr) en_q <= en_wdata;
         irq_q <= |(sta_q & en_q);
      end
   end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
   import spi_irq_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             done_pulse,
   input  logic             rx_ovf_pulse,
   input  logic             tx_udr_pulse,
   input  logic             sta_wr,
   input  logic [NSRC-1:0]  sta_wdata,
   input  logic             en_wr,
   input  logic [NSRC-1:0]  en_wdata,
   output logic [NSRC-1:0]  status,
   output logic [NSRC-1:0]  enable,
   output logic             irq
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cntw
      $error("CNT_W too narrow for DEPTH");
   end

   logic     lv_rdy, lv_hf, lv_he;
   src_vec_t set_vec;

   spi_irq_levels #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_levels (
      .rx_count (rx_count),
      .tx_count (tx_count),
      .rx_rdy   (lv_rdy),
      .rx_hf    (lv_hf),
      .tx_he    (lv_he)
   );

   always_comb begin
      set_vec            = '0;
      set_vec[SRC_DONE]  = done_pulse;
      set_vec[SRC_RXOVF] = rx_ovf_pulse;
      set_vec[SRC_TXUDR] = tx_udr_pulse;
      set_vec[SRC_RXRDY] = lv_rdy;
      set_vec[SRC_RXHF]  = lv_hf;
      set_vec[SRC_TXHE]  = lv_he;
   end

   spi_irq_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_wr   (sta_wr),
      .clr_mask (sta_wdata),
      .sta_q    (status)
   );

   spi_irq_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (en_wr),
      .en_wdata (en_wdata),
      .sta_q    (status),
      .en_q     (enable),
      .irq_q    (irq)
   );
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] rx_count,
   input logic [CNT_W-1:0] tx_count,
   input logic             done_pulse,
   input logic             rx_ovf_pulse,
   input logic             tx_udr_pulse,
   input logic             sta_wr,
   input logic [5:0]       sta_wdata,
   input logic             en_wr,
   input logic [5:0]       en_wdata,
   input logic [5:0]       status,
   input logic [5:0]       enable,
   input logic             irq
);
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DEPTH / 2);

   assert_done_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> status[0]);
   assert_ovf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf_pulse && sta_wr && sta_wdata[1]) |=> status[1]);
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sta_wr && sta_wdata[2] && !tx_udr_pulse) |=> !status[2]);
   assert_no_spurious_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sta_wr |=> ((status & $past(status)) == $past(status)));
   assert_rx_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count != '0) |=> status[3]);
   assert_rx_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count >= HALF_C) |=> status[4]);
   assert_tx_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count <= HALF_C && sta_wr && sta_wdata[5]) |=> status[5]);
   assert_en_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (enable == $past(en_wdata)));
   assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(enable));
   assert_irq_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == |($past(status & enable))));
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/spi_irq_ctrl_tb.sv
module spi_irq_ctrl_tb;
   localparam int DEPTH = 64;
   localparam int CW = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CW-1:0] rx_count = '0;
   logic [CW-1:0] tx_count = CW'(DEPTH);
   logic done_pulse = 1'b0, rx_ovf_pulse = 1'b0, tx_udr_pulse = 1'b0;
   logic sta_wr = 1'b0, en_wr = 1'b0;
   logic [5:0] sta_wdata = '0, en_wdata = '0;
   logic [5:0] status, enable;
   logic irq;

   int n_run = 0, n_fail = 0;
   bit done_flag = 0;

   always #2.5 clk = ~clk;

   spi_irq_ctrl #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
      .done_pulse(done_pulse), .rx_ovf_pulse(rx_ovf_pulse), .tx_udr_pulse(tx_udr_pulse),
      .sta_wr(sta_wr), .sta_wdata(sta_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
      .status(status), .enable(enable), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle();
      sta_wr = 0; en_wr = 0; done_pulse = 0; rx_ovf_pulse = 0; tx_udr_pulse = 0;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 status in reset", {2'b0, status}, 8'h00);
      chk("R1 enable in reset", {2'b0, enable}, 8'h00);
      chk("R1 irq in reset", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after reset", {2'b0, status}, 8'h00);
      chk("R1 irq after reset", {7'b0, irq}, 8'h00);

      // R5 R6 R7 R8: level sweep with a simultaneous clear-all
      for (int v = 0; v <= DEPTH; v++) begin
         rx_count = CW'(v); tx_count = CW'(v);
         sta_wr = 1; sta_wdata = 6'h3F;
         @(negedge clk);
         chk("R5 rx ready", {7'b0, status[3]}, {7'b0, v >= 1});
         chk("R6 rx half-full", {7'b0, status[4]}, {7'b0, v >= DEPTH/2});
         chk("R7 tx half-empty", {7'b0, status[5]}, {7'b0, v <= DEPTH/2});
         chk("R8 events cleared", {5'b0, status[2:0]}, 8'h00);
      end
      idle();

      // R2 R3 R4: event pulses against clear masks
      rx_count = '0; tx_count = CW'(DEPTH);
      for (int c = 0; c < 8; c++) begin
         for (int p = 0; p < 8; p++) begin
            done_pulse = 1; rx_ovf_pulse = 1; tx_udr_pulse = 1;
            sta_wr = 1; sta_wdata = 6'h3F;
            @(negedge clk);
            chk("R2 events latched", {2'b0, status}, 8'h07);
            done_pulse = p[0]; rx_ovf_pulse = p[1]; tx_udr_pulse = p[2];
            sta_wdata = {3'b0, 3'(c)};
            @(negedge clk);
            chk("R3 R4 clear vs set", {2'b0, status},
                {5'b0, 3'(p) | (3'b111 & ~3'(c))});
            idle();
            @(negedge clk);
            chk("R2 sticky hold", {2'b0, status},
                {5'b0, 3'(p) | (3'b111 & ~3'(c))});
         end
      end

      // R9 R10: enable values against status patterns
      for (int e = 0; e < 64; e++) begin
         for (int k = 0; k < 8; k++) begin
            logic [5:0] s;
            int rxv;
            rxv = (k % 3 == 0) ? 0 : ((k % 3 == 1) ? 5 : 40);
            s[2:0] = 3'(k) ^ 3'(e);
            s[3] = (rxv >= 1);
            s[4] = (rxv >= DEPTH/2);
            s[5] = k[2];
            rx_count = CW'(rxv); tx_count = k[2] ? CW'(10) : CW'(DEPTH);
            done_pulse = s[0]; rx_ovf_pulse = s[1]; tx_udr_pulse = s[2];
            sta_wr = 1; sta_wdata = 6'h3F;
            en_wr = 1; en_wdata = 6'(e);
            @(negedge clk);
            idle();
            chk("R9 enable written", {2'b0, enable}, {2'b0, 6'(e)});
            chk("R9 status latched regardless of enable", {2'b0, status}, {2'b0, s});
            @(negedge clk);
            chk("R10 irq", {7'b0, irq}, {7'b0, |(s & 6'(e))});
            chk("R9 enable held", {2'b0, enable}, {2'b0, 6'(e)});
         end
      end
      done_flag = 1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (150000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule